// File: doc/BRIEF.md
# Load Result Aligner and Extender

This block turns the raw doubleword returned for a load into the value that is written to the destination register. It takes the 64-bit doubleword, the low three bits of the load's physical address, a 3-bit load-kind code and a flag saying the destination is a floating-point register. The addressed byte is first moved down to bit 0, with zeros entering from the top. The result is then sign-extended or zero-extended to the access width. Word and doubleword loads bound for floating-point registers skip sign extension and pass the aligned bits through unchanged.

The formatting logic is combinational and is followed by one output register with a valid/ready handshake. A load accepted in one cycle appears at the output in the next. While the consumer holds ready low, the register keeps its value and the block refuses new input. Misaligned combinations are not detected: the block returns whatever the aligned, truncated data gives.

Top module: `ldfmt_top`

## Requirements
- R1: The byte at offset `in_offset` (0..7) of `in_data` lands at output bit 0. The data is shifted right by 8 times the offset, and the bits that enter from above are zero before extension.
- R2: Kind codes 0, 1 and 2 (signed byte, halfword, word) sign-extend bits [7:0], [15:0] and [31:0] of the aligned data to 64 bits.
- R3: Kind codes 4, 5 and 6 (unsigned byte, halfword, word) zero-extend bits [7:0], [15:0] and [31:0] of the aligned data.
- R4: Kind code 3 (doubleword) returns all 64 aligned bits unchanged.
- R5: With `in_fp_dest` set, kind 2 returns the 64 aligned bits without sign extension and kind 3 is unaffected. The flag has no effect on kinds 0, 1, 4, 5 and 6.
- R6: Kind code 7 is reserved and yields an all-zero result.
- R7: An input accepted (`in_valid` and `in_ready` high at a rising edge) shows up with `out_valid` high after exactly one clock edge. With `out_ready` held high, a new load can be accepted on every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_value` and `out_valid` hold, `in_ready` is low, and any input offered during that time is not captured.
- R9: While reset is asserted and after its release, `out_valid` is low and `in_ready` is high until a load is accepted.
- R10: Misaligned accesses are not flagged. A doubleword at offset 4 returns `in_data >> 32`, and an unsigned word at offset 6 returns `in_data[63:48]` zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load result is offered |
| in_ready | output | 1 | The block can take a load this cycle |
| in_data | input | 64 | Raw doubleword returned by memory |
| in_offset | input | 3 | Physical address bits [2:0] of the load |
| in_kind | input | 3 | Load kind code (0..6, 7 reserved) |
| in_fp_dest | input | 1 | Destination is a floating-point register |
| out_valid | output | 1 | Formatted value is present |
| out_ready | input | 1 | Consumer takes the value this cycle |
| out_value | output | 64 | Register-ready load value |

## Verification
The assertions assume the consumer follows the valid/ready rule on its side and that the input fields are stable and known whenever `in_valid` is high. They also assume that `in_kind` is one of the eight 3-bit codes. The bench changes inputs only at falling edges and holds them through the following rising edge. It draws data, offset, kind and flag from the full code space, including the reserved kind and misaligned offsets. Stalls are limited to a directed sequence in which the offered input is withdrawn before ready is raised again.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    // Load kind codes; the numeric values are part of the interface.
    typedef enum logic [2:0] {
        KIND_SB  = 3'd0,
        KIND_SH  = 3'd1,
        KIND_SW  = 3'd2,
        KIND_D   = 3'd3,
        KIND_UB  = 3'd4,
        KIND_UH  = 3'd5,
        KIND_UW  = 3'd6,
        KIND_RSV = 3'd7
    } load_kind_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/ldfmt_lane_shift.sv
module ldfmt_lane_shift #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned LANES = DATA_W / ldfmt_pkg::BYTE_W,
    localparam int unsigned OFS_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [OFS_W-1:0]  ofs,
    output logic [DATA_W-1:0] aligned
);
    // One candidate per byte lane; zeros enter from the top (R1).
    logic [DATA_W-1:0] cand [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cand[g] = raw >> (ldfmt_pkg::BYTE_W * g);
    end

    assign aligned = cand[ofs];
endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned HALF_W = 16,
    localparam int unsigned WORD_W = 32
) (
    input  logic [DATA_W-1:0]      aligned,
    input  ldfmt_pkg::load_kind_e  kind,
    input  logic                   fp_dest,
    output logic [DATA_W-1:0]      value
);
    import ldfmt_pkg::*;

    always_comb begin
        value = '0;
        unique case (kind)
            KIND_SB: value = {{(DATA_W-BYTE_W){aligned[BYTE_W-1]}}, aligned[BYTE_W-1:0]};
            KIND_SH: value = {{(DATA_W-HALF_W){aligned[HALF_W-1]}}, aligned[HALF_W-1:0]};
            KIND_SW: value = fp_dest ? aligned
                           : {{(DATA_W-WORD_W){aligned[WORD_W-1]}}, aligned[WORD_W-1:0]};
            KIND_D:  value = aligned;
            KIND_UB: value = {{(DATA_W-BYTE_W){1'b0}}, aligned[BYTE_W-1:0]};
            KIND_UH: value = {{(DATA_W-HALF_W){1'b0}}, aligned[HALF_W-1:0]};
            KIND_UW: value = {{(DATA_W-WORD_W){1'b0}}, aligned[WORD_W-1:0]};
            KIND_RSV: value = '0;
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/ldfmt_out_stage.sv
module ldfmt_out_stage #(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_value,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_value
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] value;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        up_ready = !st_q.valid || dn_ready;
        if (up_valid && up_ready) begin
            st_d.valid = 1'b1;
            st_d.value = up_value;
        end else if (dn_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dn_valid = st_q.valid;
    assign dn_value = st_q.value;

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_value))
        else $error("output changed during stall");

    assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |-> !up_ready)
        else $error("input accepted during stall");

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid && up_ready |=> dn_valid)
        else $error("accepted load missing next cycle");

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> !dn_valid)
        else $error("valid after reset");
endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned LANES = DATA_W / ldfmt_pkg::BYTE_W,
    localparam int unsigned OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [OFS_W-1:0]  in_offset,
    input  logic [2:0]        in_kind,
    input  logic              in_fp_dest,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_value
);
    import ldfmt_pkg::*;

    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] formatted;
    load_kind_e        kind;

    assign kind = load_kind_e'(in_kind);

    ldfmt_lane_shift #(.DATA_W(DATA_W)) u_shift (
        .raw     (in_data),
        .ofs     (in_offset),
        .aligned (aligned)
    );

    ldfmt_extend #(.DATA_W(DATA_W)) u_ext (
        .aligned (aligned),
        .kind    (kind),
        .fp_dest (in_fp_dest),
        .value   (formatted)
    );

    ldfmt_out_stage #(.DATA_W(DATA_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_value (formatted),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_value (out_value)
    );

    logic take;
    assign take = in_valid && in_ready;

    assert_unsigned_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_kind == 3'd4 |=> out_value[DATA_W-1:BYTE_W] == '0)
        else $error("unsigned byte has upper bits set");

    assert_signed_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_kind == 3'd0 |=> out_value[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){out_value[BYTE_W-1]}})
        else $error("signed byte not sign-extended");

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_kind == 3'd7 |=> out_value == '0)
        else $error("reserved kind produced nonzero");

    assert_lane_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_kind == 3'd3 && in_offset == OFS_W'(LANES-1) |=> out_value[DATA_W-1:BYTE_W] == '0)
        else $error("top lane shift did not zero-fill");
endmodule

// File: tb/ldfmt_top_test.sv
`timescale 1ns/1ps
module ldfmt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic [2:0]  in_offset = '0;
    logic [2:0]  in_kind = '0;
    logic        in_fp_dest = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_value;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ldfmt_top uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_offset(in_offset), .in_kind(in_kind), .in_fp_dest(in_fp_dest),
        .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value)
    );

    // Expected result from the requirements (R1..R6, R10).
    function automatic logic [63:0] model(input logic [63:0] d, input logic [2:0] o,
                                          input logic [2:0] k, input logic fp);
        logic [63:0] s;
        s = d >> (8 * o);
        case (k)
            3'd0: model = {{56{s[7]}}, s[7:0]};
            3'd1: model = {{48{s[15]}}, s[15:0]};
            3'd2: model = fp ? s : {{32{s[31]}}, s[31:0]};
            3'd3: model = s;
            3'd4: model = {56'd0, s[7:0]};
            3'd5: model = {48'd0, s[15:0]};
            3'd6: model = {32'd0, s[31:0]};
            default: model = 64'd0;
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    // One isolated load: drive, accept, check, drain.
    task automatic one(input logic [63:0] d, input logic [2:0] o, input logic [2:0] k,
                       input logic fp, input string req);
        logic [63:0] e;
        e = model(d, o, k, fp);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_offset = o; in_kind = k; in_fp_dest = fp;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R7", {63'd0, out_valid}, 64'd1);
        check(out_value === e, req, out_value, e);
    endtask

    initial begin
        logic [63:0] pat;
        logic [63:0] prev_e;
        logic [63:0] stall_e;
        void'($urandom(32'd20240611));

        // R9: reset state
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R9", {63'd0, out_valid}, 64'd0);
        check(in_ready === 1'b1, "R9", {63'd0, in_ready}, 64'd1);

        pat = 64'h80F1_7F82_8001_FF80;
        // R1: each offset with unsigned byte shows the addressed byte
        for (int o = 0; o < 8; o++) one(pat, 3'(o), 3'd4, 1'b0, "R1");
        // R2 signed
        one(pat, 3'd0, 3'd0, 1'b0, "R2");
        one(pat, 3'd2, 3'd1, 1'b0, "R2");
        one(pat, 3'd4, 3'd2, 1'b0, "R2");
        one(64'h0000_0000_7FFF_FFFF, 3'd0, 3'd2, 1'b0, "R2");
        // R3 unsigned
        one(pat, 3'd0, 3'd5, 1'b0, "R3");
        one(pat, 3'd4, 3'd6, 1'b0, "R3");
        // R4 doubleword
        one(pat, 3'd0, 3'd3, 1'b0, "R4");
        // R5 floating-point destination
        one(pat, 3'd4, 3'd2, 1'b1, "R5");
        one(pat, 3'd0, 3'd2, 1'b1, "R5");
        one(pat, 3'd0, 3'd3, 1'b1, "R5");
        one(pat, 3'd0, 3'd0, 1'b1, "R5");
        one(pat, 3'd2, 3'd1, 1'b1, "R5");
        // R6 reserved
        one(64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 3'd7, 1'b0, "R6");
        one(64'hFFFF_FFFF_FFFF_FFFF, 3'd0, 3'd7, 1'b1, "R6");
        // R10 misaligned
        one(64'h1234_5678_9ABC_DEF0, 3'd4, 3'd3, 1'b0, "R10");
        one(64'h1234_5678_9ABC_DEF0, 3'd6, 3'd6, 1'b0, "R10");
        one(64'h8234_5678_9ABC_DEF0, 3'd5, 3'd2, 1'b0, "R10");

        // R8: stall holds value and blocks new input
        stall_e = model(pat, 3'd1, 3'd1, 1'b0);
        @(negedge clk);
        in_valid = 1'b1; in_data = pat; in_offset = 3'd1; in_kind = 3'd1; in_fp_dest = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        in_data = 64'hDEAD_BEEF_0000_1111; in_kind = 3'd3; in_offset = 3'd0;
        check(in_ready === 1'b0, "R8", {63'd0, in_ready}, 64'd0);
        check(out_value === stall_e, "R8", out_value, stall_e);
        @(negedge clk);
        check(out_valid === 1'b1, "R8", {63'd0, out_valid}, 64'd1);
        check(out_value === stall_e, "R8", out_value, stall_e);
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R8", {63'd0, out_valid}, 64'd0);

        // R7: streaming random loads, one per cycle
        prev_e = '0;
        for (int i = 0; i < 600; i++) begin
            logic [63:0] d;
            logic [2:0]  o;
            logic [2:0]  k;
            logic        fp;
            d = {$urandom, $urandom};
            o = 3'($urandom);
            k = 3'($urandom);
            fp = 1'($urandom);
            @(negedge clk);
            if (i > 0) begin
                check(out_valid === 1'b1, "R7", {63'd0, out_valid}, 64'd1);
                check(out_value === prev_e, "R7", out_value, prev_e);
            end
            check(in_ready === 1'b1, "R7", {63'd0, in_ready}, 64'd1);
            in_valid = 1'b1; in_data = d; in_offset = o; in_kind = k; in_fp_dest = fp;
            prev_e = model(d, o, k, fp);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_value === prev_e, "R7", out_value, prev_e);
        @(negedge clk);
        check(out_valid === 1'b0, "R7", {63'd0, out_valid}, 64'd0);

        finish_run();
    end
endmodule